// File: doc/BRIEF.md
# Three-Tier Memory Address Router

This block sits between a small processor core and the memories that core can reach through one flat word address space. The core has two request ports: an instruction-fetch port driven by a program counter wider than 9 bits, and a data port for loads and stores. The router decodes each address and sends the access to one of three tiers. The first tier is a 512-word register file with two read ports. The second is a private single-port extended RAM. The third is a shared RAM that is reached through an external slot arbiter with a request/grant pair. Operand fields inside instructions stay 9 bits wide, so they only reach the register file. The wider fetch and data addresses reach every tier.

Every access uses the same handshake. The core raises a request and holds it until the matching ready is high. The access is then accepted, and the response (valid, data, fault) appears in the next cycle whatever the tier. Only the time spent waiting for ready differs. Local tiers accept at once, unless the fetch and the data port both want the extended RAM. Shared accesses wait until the arbiter grants.

A reserved gap between the extended RAM and the shared region faults without touching any memory. A boot-image window at the bottom of the shared region is locked out once boot has finished. Shared addresses leave the router unchanged, with no remapping.

Top module: `memTierRouter`

## Requirements
- R1: Addresses 0x000 to 0x1FF select the register file. An access is accepted in the cycle it is requested. A read returns the last word written there. A fetch read and a data read that both target the register file in the same cycle are both accepted without a stall.
- R2: Addresses 0x200 to 0x5FF select the extended RAM. The access is accepted in the cycle it is requested and never raises the shared request. Reads return the last word written at that address.
- R3: When the fetch port and the data port both target the extended RAM in the same cycle, the data access is accepted and the fetch is held off (fetch ready low) for exactly that cycle. The fetch is accepted in the next cycle.
- R4: Addresses 0x600 to 0x7FF are reserved. Such an access is accepted at once. Its response has fault = 1 and data = 0. It raises no shared request. A write to it leaves the register file and the extended RAM unchanged.
- R5: Addresses 0x800 to 0x3FFF select shared memory. The shared request is raised with the core's address, write flag and write data passed through unchanged. The port's ready stays low until the grant arrives. The response carries the shared read data that was present in the grant cycle.
- R6: When both ports target shared memory in the same cycle, the data access owns the shared request and is granted first. The fetch waits at least one more cycle.
- R7: Before boot is signalled, every shared address is allowed. From the cycle after bootDone is sampled high, shared addresses 0x800 to 0x8FF fault in the same way as R4. This lockout holds until reset, even if bootDone is later lowered.
- R8: After reset, fValid and dValid are low. Each accepted access produces exactly one valid response, exactly one cycle after acceptance, and no valid appears otherwise. Write responses have fault = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootDone | input | 1 | Boot finished; registered and sticky, enables the low shared lockout |
| fReq | input | 1 | Instruction fetch request |
| fAddr | input | 14 | Fetch word address (program counter) |
| fReady | output | 1 | Fetch accepted this cycle |
| fValid | output | 1 | Fetch response valid |
| fData | output | 32 | Fetched instruction word |
| fFault | output | 1 | Fetch hit a reserved or locked address |
| dReq | input | 1 | Data access request |
| dWe | input | 1 | Data access is a write |
| dAddr | input | 14 | Data word address |
| dWdata | input | 32 | Data write word |
| dReady | output | 1 | Data access accepted this cycle |
| dValid | output | 1 | Data response valid |
| dData | output | 32 | Data read word (zero for writes and faults) |
| dFault | output | 1 | Data access hit a reserved or locked address |
| shReq | output | 1 | Request to the shared-memory slot arbiter |
| shWe | output | 1 | Shared access is a write |
| shAddr | output | 14 | Shared word address, unchanged |
| shWdata | output | 32 | Shared write word |
| shGrant | input | 1 | Arbiter grant; the shared access happens in this cycle |
| shRdata | input | 32 | Shared read word, valid in the grant cycle |

## Verification
The bench probes every tier edge: 0x1FF/0x200, 0x5FF/0x600, 0x7FF/0x800 and the top of the space. An off-by-one decode would return a word from the wrong array or raise a false fault. A reserved write is followed by a read of extended address 0x200. A design that folded the reserved range into the extended RAM by truncating the index would overwrite that word. Same-cycle collisions are checked by counting how long each port waits. A design without the extended-RAM rule would accept both ports at once, and a wrong shared priority would grant the fetch first. The arbiter grant is delayed by a random number of cycles, so a router that did not stall, or that latched stale shared data, returns wrong words. The lockout is checked on both sides of bootDone and after bootDone is lowered again. A non-sticky lock would let the boot window through again.

// File: rtl/mrPkg.sv
`timescale 1ns/1ps
package mrPkg;

  typedef enum logic [1:0] {
    TIER_REG = 2'd0,
    TIER_EXT = 2'd1,
    TIER_SHR = 2'd2,
    TIER_BAD = 2'd3
  } tier_e;

  // Strobes from control to datapath, all qualified by acceptance.
  typedef struct packed {
    logic accF;
    logic accD;
    logic regRdF;
    logic regRdD;
    logic regWrD;
    logic extRdF;
    logic extRdD;
    logic extWrD;
    logic shrF;
    logic shrD;
    logic shrSelD;
    logic badF;
    logic badD;
  } strobe_t;

endpackage

// File: rtl/mrControl.sv
`timescale 1ns/1ps
module mrControl
  import mrPkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int REG_WORDS  = 512,
  parameter int EXT_WORDS  = 1024,
  parameter int RSV_WORDS  = 512,
  parameter int BOOT_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootDone,
  input  logic              fReq,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic              dReq,
  input  logic              dWe,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              shGrant,
  output logic              fReady,
  output logic              dReady,
  output logic              shReq,
  output strobe_t           stb
);
  // Bounds are derived from sizes, so they are ascending by construction.
  localparam logic [ADDR_W:0] EXT_BASE = (ADDR_W+1)'(REG_WORDS);
  localparam logic [ADDR_W:0] RSV_BASE = EXT_BASE + (ADDR_W+1)'(EXT_WORDS);
  localparam logic [ADDR_W:0] SHR_BASE = RSV_BASE + (ADDR_W+1)'(RSV_WORDS);
  localparam logic [ADDR_W:0] BOOT_END = SHR_BASE + (ADDR_W+1)'(BOOT_WORDS);

  logic  bootLock;
  tier_e fTier, dTier;
  logic  dShr, fShr, extClash;

  function automatic tier_e classify(input logic [ADDR_W-1:0] a, input logic lk);
    logic [ADDR_W:0] w;
    w = {1'b0, a};
    if (w < EXT_BASE)             return TIER_REG;
    else if (w < RSV_BASE)        return TIER_EXT;
    else if (w < SHR_BASE)        return TIER_BAD;
    else if (lk && w < BOOT_END)  return TIER_BAD;
    else                          return TIER_SHR;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) bootLock <= 1'b0;
    else       bootLock <= bootLock | bootDone;
  end

  always_comb begin
    fTier    = classify(fAddr, bootLock);
    dTier    = classify(dAddr, bootLock);
    dShr     = dReq && (dTier == TIER_SHR);
    fShr     = fReq && (fTier == TIER_SHR);
    extClash = dReq && (dTier == TIER_EXT) && fReq && (fTier == TIER_EXT);

    dReady = dShr ? shGrant : 1'b1;
    unique case (fTier)
      TIER_EXT: fReady = !extClash;
      TIER_SHR: fReady = !dShr && shGrant;
      default:  fReady = 1'b1;
    endcase
    shReq = dShr || fShr;

    stb         = '0;
    stb.accD    = dReq && dReady;
    stb.accF    = fReq && fReady;
    stb.regRdD  = stb.accD && (dTier == TIER_REG) && !dWe;
    stb.regWrD  = stb.accD && (dTier == TIER_REG) &&  dWe;
    stb.extRdD  = stb.accD && (dTier == TIER_EXT) && !dWe;
    stb.extWrD  = stb.accD && (dTier == TIER_EXT) &&  dWe;
    stb.shrD    = stb.accD && (dTier == TIER_SHR);
    stb.badD    = stb.accD && (dTier == TIER_BAD);
    stb.regRdF  = stb.accF && (fTier == TIER_REG);
    stb.extRdF  = stb.accF && (fTier == TIER_EXT);
    stb.shrF    = stb.accF && (fTier == TIER_SHR);
    stb.badF    = stb.accF && (fTier == TIER_BAD);
    stb.shrSelD = dShr;
  end

  assert_reg_dual_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fReq && dReq && fTier == TIER_REG && dTier == TIER_REG) |-> (fReady && dReady));

  assert_ext_data_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    extClash |-> (dReady && !fReady));

  assert_ext_one_port_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.extRdF && (stb.extRdD || stb.extWrD)));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    bootLock |=> bootLock);

endmodule

// File: rtl/mrDatapath.sv
`timescale 1ns/1ps
module mrDatapath
  import mrPkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 32,
  parameter int REG_WORDS = 512,
  parameter int EXT_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] fAddr,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              dWe,
  input  logic [DATA_W-1:0] dWdata,
  input  logic [DATA_W-1:0] shRdata,
  output logic [ADDR_W-1:0] shAddr,
  output logic              shWe,
  output logic [DATA_W-1:0] shWdata,
  output logic              fValid,
  output logic [DATA_W-1:0] fData,
  output logic              fFault,
  output logic              dValid,
  output logic [DATA_W-1:0] dData,
  output logic              dFault
);
  localparam int RW = $clog2(REG_WORDS);
  localparam int EW = $clog2(EXT_WORDS);
  localparam logic [ADDR_W-1:0] EXT_OFS = ADDR_W'(REG_WORDS);

  logic [DATA_W-1:0] regFile [REG_WORDS];
  logic [DATA_W-1:0] extRam  [EXT_WORDS];

  logic [RW-1:0] fRegIdx, dRegIdx;
  logic [EW-1:0] fExtIdx, dExtIdx;

  always_comb begin
    fRegIdx = fAddr[RW-1:0];
    dRegIdx = dAddr[RW-1:0];
    fExtIdx = EW'(fAddr - EXT_OFS);
    dExtIdx = EW'(dAddr - EXT_OFS);
    shAddr  = stb.shrSelD ? dAddr : fAddr;
    shWe    = stb.shrSelD && dWe;
    shWdata = dWdata;
  end

  always_ff @(posedge clk) begin
    if (stb.regWrD) regFile[dRegIdx] <= dWdata;
    if (stb.extWrD) extRam[dExtIdx]  <= dWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fValid <= 1'b0;
      fFault <= 1'b0;
      fData  <= '0;
      dValid <= 1'b0;
      dFault <= 1'b0;
      dData  <= '0;
    end else begin
      fValid <= stb.accF;
      fFault <= stb.badF;
      if (stb.regRdF)      fData <= regFile[fRegIdx];
      else if (stb.extRdF) fData <= extRam[fExtIdx];
      else if (stb.shrF)   fData <= shRdata;
      else                 fData <= '0;

      dValid <= stb.accD;
      dFault <= stb.badD;
      if (stb.regRdD)                 dData <= regFile[dRegIdx];
      else if (stb.extRdD)            dData <= extRam[dExtIdx];
      else if (stb.shrD && !dWe)      dData <= shRdata;
      else                            dData <= '0;
    end
  end

endmodule

// File: rtl/memTierRouter.sv
`timescale 1ns/1ps
module memTierRouter
  import mrPkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 32,
  parameter int REG_WORDS  = 512,
  parameter int EXT_WORDS  = 1024,
  parameter int RSV_WORDS  = 512,
  parameter int BOOT_WORDS = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootDone,
  input  logic              fReq,
  input  logic [ADDR_W-1:0] fAddr,
  output logic              fReady,
  output logic              fValid,
  output logic [DATA_W-1:0] fData,
  output logic              fFault,
  input  logic              dReq,
  input  logic              dWe,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic [DATA_W-1:0] dWdata,
  output logic              dReady,
  output logic              dValid,
  output logic [DATA_W-1:0] dData,
  output logic              dFault,
  output logic              shReq,
  output logic              shWe,
  output logic [ADDR_W-1:0] shAddr,
  output logic [DATA_W-1:0] shWdata,
  input  logic              shGrant,
  input  logic [DATA_W-1:0] shRdata
);
  localparam logic [ADDR_W:0] SHR_BASE =
    (ADDR_W+1)'(REG_WORDS + EXT_WORDS + RSV_WORDS);

  strobe_t stb;

  mrControl #(
    .ADDR_W(ADDR_W), .REG_WORDS(REG_WORDS), .EXT_WORDS(EXT_WORDS),
    .RSV_WORDS(RSV_WORDS), .BOOT_WORDS(BOOT_WORDS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bootDone(bootDone),
    .fReq(fReq), .fAddr(fAddr), .dReq(dReq), .dWe(dWe), .dAddr(dAddr),
    .shGrant(shGrant), .fReady(fReady), .dReady(dReady), .shReq(shReq),
    .stb(stb)
  );

  mrDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_WORDS(REG_WORDS), .EXT_WORDS(EXT_WORDS)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fAddr(fAddr), .dAddr(dAddr), .dWe(dWe), .dWdata(dWdata), .shRdata(shRdata),
    .shAddr(shAddr), .shWe(shWe), .shWdata(shWdata),
    .fValid(fValid), .fData(fData), .fFault(fFault),
    .dValid(dValid), .dData(dData), .dFault(dFault)
  );

  assert_data_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dReq && dReady) |=> dValid);
  assert_data_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(dReq && dReady) |=> !dValid);
  assert_fetch_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fReq && fReady) |=> fValid);
  assert_fetch_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(fReq && fReady) |=> !fValid);
  assert_shr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    shReq |-> ({1'b0, shAddr} >= SHR_BASE));
  assert_data_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dReq && !dReady) |-> (shReq && !shGrant));

endmodule

// File: tb/tb_memTierRouter.sv
`timescale 1ns/1ps
module tb_memTierRouter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootDone = 1'b0;
  logic        fReq = 1'b0;
  logic [13:0] fAddr = '0;
  logic        fReady, fValid, fFault;
  logic [31:0] fData;
  logic        dReq = 1'b0, dWe = 1'b0;
  logic [13:0] dAddr = '0;
  logic [31:0] dWdata = '0;
  logic        dReady, dValid, dFault;
  logic [31:0] dData;
  logic        shReq, shWe;
  logic [13:0] shAddr;
  logic [31:0] shWdata;
  logic        shGrant = 1'b0;
  logic [31:0] shRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        fault;
    logic [31:0] data;
    bit          chk;
    string       rq;
  } exp_t;
  exp_t fQ[$];
  exp_t dQ[$];

  always #2.5 clk = ~clk;

  memTierRouter dut (
    .clk(clk), .rstN(rstN), .bootDone(bootDone),
    .fReq(fReq), .fAddr(fAddr), .fReady(fReady), .fValid(fValid), .fData(fData), .fFault(fFault),
    .dReq(dReq), .dWe(dWe), .dAddr(dAddr), .dWdata(dWdata),
    .dReady(dReady), .dValid(dValid), .dData(dData), .dFault(dFault),
    .shReq(shReq), .shWe(shWe), .shAddr(shAddr), .shWdata(shWdata),
    .shGrant(shGrant), .shRdata(shRdata)
  );

  function automatic logic [31:0] shPat(input logic [13:0] a);
    return 32'h5A00_0000 ^ {18'd0, a};
  endfunction

  assign shRdata = shPat(shAddr);

  function automatic void check(input bit ok, input string rq, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endfunction

  // Arbiter model: grant after a random 0..3 cycle delay, one cycle wide.
  initial begin
    int waitLeft;
    waitLeft = -1;
    forever begin
      @(posedge clk);
      #1;
      if (shGrant) begin
        shGrant  = 1'b0;
        waitLeft = -1;
      end else if (shReq) begin
        if (waitLeft < 0) waitLeft = $urandom_range(0, 3);
        if (waitLeft == 0) shGrant = 1'b1;
        else waitLeft--;
      end else begin
        waitLeft = -1;
      end
    end
  end

  // Monitor: pops expected responses as they appear.
  always @(negedge clk) begin
    if (rstN) begin
      if (dValid) begin
        if (dQ.size() == 0) check(0, "R8", "unexpected data response", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = dQ.pop_front();
          check(dFault == e.fault, e.rq, "data fault", {31'd0, dFault}, {31'd0, e.fault});
          if (e.chk) check(dData == e.data, e.rq, "data word", dData, e.data);
        end
      end
      if (fValid) begin
        if (fQ.size() == 0) check(0, "R8", "unexpected fetch response", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = fQ.pop_front();
          check(fFault == e.fault, e.rq, "fetch fault", {31'd0, fFault}, {31'd0, e.fault});
          if (e.chk) check(fData == e.data, e.rq, "fetch word", fData, e.data);
        end
      end
    end
  end

  task automatic dataOp(input logic we, input logic [13:0] a, input logic [31:0] wd,
                        input logic expF, input logic [31:0] expD, input bit chk,
                        input bit isShr, input bit solo, input string rq, output int waits);
    @(posedge clk);
    #0.5;
    dReq = 1'b1; dWe = we; dAddr = a; dWdata = wd;
    waits = 0;
    forever begin
      @(negedge clk);
      if (dReady) break;
      waits++;
    end
    if (isShr) begin
      check(shGrant && shAddr == a, rq, "shared addr at grant", {18'd0, shAddr}, {18'd0, a});
      if (we) check(shWe && shWdata == wd, rq, "shared write word", shWdata, wd);
    end else if (solo) begin
      check(!shReq && waits == 0, rq, "local access no shared req", {31'd0, shReq}, 32'd0);
    end
    dQ.push_back('{expF, expD, chk, rq});
    @(posedge clk);
    #0.5;
    dReq = 1'b0; dWe = 1'b0;
  endtask

  task automatic fetchOp(input logic [13:0] a, input logic expF, input logic [31:0] expD,
                         input bit isShr, input string rq, output int waits);
    @(posedge clk);
    #0.5;
    fReq = 1'b1; fAddr = a;
    waits = 0;
    forever begin
      @(negedge clk);
      if (fReady) break;
      waits++;
    end
    if (isShr) check(shGrant && shAddr == a, rq, "fetch shared addr", {18'd0, shAddr}, {18'd0, a});
    fQ.push_back('{expF, expD, 1'b1, rq});
    @(posedge clk);
    #0.5;
    fReq = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "R8", "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int dw, fw;
    logic [13:0] shAddrs [6];
    shAddrs = '{14'h800, 14'h8FF, 14'h900, 14'h1234, 14'h2ABC, 14'h3FFF};

    repeat (3) @(posedge clk);
    #0.5 rstN = 1'b1;
    @(negedge clk);
    check(!fValid && !dValid && !fFault && !dFault, "R8", "reset outputs",
          {28'd0, fValid, dValid, fFault, dFault}, 32'd0);

    // R1 / R2 writes at tier edges
    dataOp(1, 14'h000, 32'h1111_0000, 0, 0, 0, 0, 1, "R1", dw);
    dataOp(1, 14'h1FF, 32'h1111_01FF, 0, 0, 0, 0, 1, "R1", dw);
    dataOp(1, 14'h200, 32'h2222_0200, 0, 0, 0, 0, 1, "R2", dw);
    dataOp(1, 14'h5FF, 32'h2222_05FF, 0, 0, 0, 0, 1, "R2", dw);
    // read back
    dataOp(0, 14'h1FF, 0, 0, 32'h1111_01FF, 1, 0, 1, "R1", dw);
    dataOp(0, 14'h200, 0, 0, 32'h2222_0200, 1, 0, 1, "R2", dw);
    dataOp(0, 14'h5FF, 0, 0, 32'h2222_05FF, 1, 0, 1, "R2", dw);
    fetchOp(14'h000, 0, 32'h1111_0000, 0, "R1", fw);
    fetchOp(14'h200, 0, 32'h2222_0200, 0, "R2", fw);

    // R1 dual register reads in one cycle
    fork
      dataOp(0, 14'h000, 0, 0, 32'h1111_0000, 1, 0, 0, "R1", dw);
      fetchOp(14'h1FF, 0, 32'h1111_01FF, 0, "R1", fw);
    join
    check(dw == 0 && fw == 0, "R1", "dual register read waits", dw + fw, 32'd0);

    // R3 extended RAM clash
    fork
      dataOp(0, 14'h200, 0, 0, 32'h2222_0200, 1, 0, 0, "R3", dw);
      fetchOp(14'h5FF, 0, 32'h2222_05FF, 0, "R3", fw);
    join
    check(dw == 0, "R3", "data waits on ext clash", dw, 32'd0);
    check(fw == 1, "R3", "fetch waits on ext clash", fw, 32'd1);

    // R4 reserved gap
    dataOp(1, 14'h600, 32'hDEAD_BEEF, 1, 0, 0, 0, 1, "R4", dw);
    dataOp(0, 14'h7FF, 0, 1, 32'h0, 1, 0, 1, "R4", dw);
    fetchOp(14'h7FF, 1, 32'h0, 0, "R4", fw);
    fetchOp(14'h600, 1, 32'h0, 0, "R4", fw);
    dataOp(0, 14'h200, 0, 0, 32'h2222_0200, 1, 0, 1, "R4", dw);

    // R5 shared reads and writes with random grant delay; R7 pre-boot window open
    foreach (shAddrs[i]) begin
      dataOp(0, shAddrs[i], 0, 0, shPat(shAddrs[i]), 1, 1, 0,
             (shAddrs[i] < 14'h900) ? "R7" : "R5", dw);
      fetchOp(shAddrs[i] ^ 14'h0011, 0, shPat(shAddrs[i] ^ 14'h0011), 1, "R5", fw);
    end
    dataOp(1, 14'h1234, 32'hC0FF_EE00, 0, 0, 0, 1, 0, "R5", dw);
    dataOp(1, 14'h0850, 32'hC0FF_EE01, 0, 0, 0, 1, 0, "R7", dw);

    // R6 both ports to shared
    for (int k = 0; k < 3; k++) begin
      fork
        dataOp(0, 14'h900 + 14'(k), 0, 0, shPat(14'h900 + 14'(k)), 1, 1, 0, "R6", dw);
        fetchOp(14'hA00 + 14'(k), 0, shPat(14'hA00 + 14'(k)), 1, "R6", fw);
      join
      check(fw > dw, "R6", "fetch waits longer than data", fw, dw + 1);
    end

    // R7 lockout
    @(posedge clk);
    #0.5 bootDone = 1'b1;
    @(posedge clk);
    #0.5 bootDone = 1'b0;
    dataOp(0, 14'h800, 0, 1, 32'h0, 1, 0, 1, "R7", dw);
    dataOp(1, 14'h8FF, 32'h1234_5678, 1, 0, 0, 0, 1, "R7", dw);
    fetchOp(14'h880, 1, 32'h0, 0, "R7", fw);
    dataOp(0, 14'h900, 0, 0, shPat(14'h900), 1, 1, 0, "R7", dw);
    repeat (4) @(posedge clk);
    dataOp(0, 14'h8FF, 0, 1, 32'h0, 1, 0, 1, "R7", dw);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dQ.size() == 0 && fQ.size() == 0, "R8", "all responses seen",
          dQ.size() + fQ.size(), 32'd0);
    finishRun();
  end

endmodule